// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance and Exception Entry Unit

This block sits beside an instruction execution engine. Each time an instruction completes, it decides whether a pending prioritized interrupt is taken. When it takes an interrupt, or when the engine reports a trap or fault, it runs the exception entry sequence on a 16-bit word bus. The sequence stacks a three-part frame, switches to supervisor state and loads the new program counter from the vector table.

The block holds the architectural status word, the program counter, the supervisor and user stack pointers, and the level currently in service. The execution engine updates the status word, the PC and the user stack pointer through simple write strobes. Those strobes take effect only while no sequence is running. After reset the block fetches the initial supervisor stack pointer and program counter from the bottom of memory before it accepts anything.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset the block reads the words at byte addresses 0, 2, 4 and 6. The supervisor stack pointer becomes {word0, word2} and the PC becomes {word4, word6}. The status word becomes RESET_SR (default 16'h2700), the in-service level becomes 0, the user stack pointer becomes 0, and busy_o falls once the PC is loaded.
- R2: While irq_active_i is high, the pending level follows irq_level_i. The vector number is captured only when the level changes to a nonzero value, so a vector change at an unchanged level is not recorded. While irq_active_i is low, the pending level is 0.
- R3: At a completed-instruction strobe in the idle state, an interrupt is taken only if three conditions hold: the pending level is nonzero; it is at least the mask in status bits 10:8, or it equals 7; and it is at least the in-service level. Otherwise no bus cycle starts.
- R4: When an interrupt is taken, the in-service level becomes the pending level, and status bits 10:8 are rewritten with that level.
- R5: At a strobe where no interrupt is taken and no trap is requested, a pending level below the in-service level lowers the in-service level to the pending level.
- R6: Entry with stack pointer SP and vector V performs four word writes in this order: V*4 at SP-2, PC[31:16] at SP-6, PC[15:0] at SP-4, and the old status word at SP-8. The stack pointer ends at SP-8.
- R7: The frame goes to the supervisor stack pointer when status bit 13 is set at entry, and to the user stack pointer otherwise. The other pointer is left unchanged.
- R8: After the pushes, status bit 13 is set and bit 15 is cleared. The block then reads two words at VBR+V*4 (high word first) and loads them as the new PC.
- R9: A trap request at the strobe takes precedence over an interrupt. The vector is TRAP_BASE (32) plus trap_num_i when trap_sw_i is set, and trap_vec_i otherwise. A trap leaves the mask bits and the in-service level unchanged.
- R10: busy_o is high from the start of an entry sequence until the second vector word is acknowledged. Strobes and write ports seen while busy_o is high have no effect.
- R11: A bus request holds its address and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_active_i | input | 1 | Interrupt line asserted |
| irq_level_i | input | 3 | Priority of the asserted interrupt |
| irq_vec_i | input | 8 | Vector number of the asserted interrupt |
| insn_done_i | input | 1 | Instruction boundary strobe |
| trap_req_i | input | 1 | Trap or fault requests entry at this boundary |
| trap_sw_i | input | 1 | Request is a software trap numbered by trap_num_i |
| trap_num_i | input | 4 | Software trap number |
| trap_vec_i | input | 8 | Vector number for a non-software trap or fault |
| vbr_i | input | 32 | Vector table base address |
| sr_we_i | input | 1 | Load status word from sr_wd_i |
| sr_wd_i | input | 16 | Status word write data |
| pc_we_i | input | 1 | Load PC from pc_wd_i |
| pc_wd_i | input | 32 | PC write data |
| usp_we_i | input | 1 | Load user stack pointer from usp_wd_i |
| usp_wd_i | input | 32 | User stack pointer write data |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | 32 | Byte address of the word |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid with bus_ack_i |
| bus_ack_i | input | 1 | Access complete |
| busy_o | output | 1 | Reset fetch or entry sequence in progress |
| sr_o | output | 16 | Status word |
| pc_o | output | 32 | Program counter |
| ssp_o | output | 32 | Supervisor stack pointer |
| usp_o | output | 32 | User stack pointer |
| svc_level_o | output | 3 | Interrupt level in service |

## Verification
The embedded properties check several rules on every cycle. An unacknowledged request keeps its address. The pending level clears when the line drops, and a new nonzero level captures its vector. The in-service level never rises without an acceptance. Supervisor state is already set during the vector fetch, with the accepted level in the mask, and the PC changes only on the final read of a sequence.

Only the directed scenarios can show the rest: the exact frame contents and their write order, the choice between the two stack pointers, and the precedence of a trap over a pending interrupt. They also cover the inclusive comparisons, which let an equal level be taken and let the in-service level step down by only part of the way, and the non-maskable level 7.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 32;

    localparam int SR_TRACE = 15;
    localparam int SR_SUPER = 13;
    localparam int SR_MLO   = 8;

    typedef enum logic [3:0] {
        ST_RSP_H, ST_RSP_L, ST_RPC_H, ST_RPC_L,
        ST_IDLE,
        ST_PUSH_OFS, ST_PUSH_PCH, ST_PUSH_PCL, ST_PUSH_SR,
        ST_VEC_H, ST_VEC_L
    } seq_state_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_active_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic [LVL_W-1:0] svc_i,
    output logic [LVL_W-1:0] pend_lvl_o,
    output logic [VEC_W-1:0] pend_vec_o,
    output logic             accept_o
);
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } pend_t;

    localparam logic [LVL_W-1:0] LVL_TOP = '1;

    pend_t            pend_d, pend_q;
    logic [LVL_W-1:0] line_lvl;

    always_comb begin
        pend_d   = pend_q;
        line_lvl = irq_active_i ? irq_level_i : '0;
        if (line_lvl != pend_q.lvl) begin
            pend_d.lvl = line_lvl;
            if (line_lvl != '0) pend_d.vec = irq_vec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_lvl_o = pend_q.lvl;
    assign pend_vec_o = pend_q.vec;
    assign accept_o   = (pend_q.lvl != '0)
                      && ((pend_q.lvl >= mask_i) || (pend_q.lvl == LVL_TOP))
                      && (pend_q.lvl >= svc_i);

    // R2: a dropped line leaves nothing pending
    p_drop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_active_i |=> (pend_lvl_o == '0));

    // R2: a new nonzero level captures its vector
    p_vec_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active_i && irq_level_i != '0 && irq_level_i != pend_lvl_o)
        |=> (pend_vec_o == $past(irq_vec_i)));
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter logic [15:0] RESET_SR  = 16'h2700,
    parameter int          TRAP_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_active_i,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic [VEC_W-1:0]  irq_vec_i,
    input  logic              insn_done_i,
    input  logic              trap_req_i,
    input  logic              trap_sw_i,
    input  logic [3:0]        trap_num_i,
    input  logic [VEC_W-1:0]  trap_vec_i,
    input  logic [ADDR_W-1:0] vbr_i,
    input  logic              sr_we_i,
    input  logic [WORD_W-1:0] sr_wd_i,
    input  logic              pc_we_i,
    input  logic [ADDR_W-1:0] pc_wd_i,
    input  logic              usp_we_i,
    input  logic [ADDR_W-1:0] usp_wd_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [WORD_W-1:0] bus_wdata_o,
    input  logic [WORD_W-1:0] bus_rdata_i,
    input  logic              bus_ack_i,
    output logic              busy_o,
    output logic [WORD_W-1:0] sr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] ssp_o,
    output logic [ADDR_W-1:0] usp_o,
    output logic [LVL_W-1:0]  svc_level_o
);
    localparam int SR_MHI = SR_MLO + LVL_W - 1;
    localparam logic [ADDR_W-1:0] WORD_B = ADDR_W'(WORD_W / 8);
    localparam logic [ADDR_W-1:0] LONG_B = ADDR_W'(2 * WORD_W / 8);

    typedef struct packed {
        seq_state_t        state;
        logic [WORD_W-1:0] sr;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ssp;
        logic [ADDR_W-1:0] usp;
        logic [LVL_W-1:0]  svc;
        logic [VEC_W-1:0]  vec;
        logic              irq;
        logic [WORD_W-1:0] hold;
    } regs_t;

    regs_t r_d, r_q;

    logic [LVL_W-1:0]  pend_lvl;
    logic [VEC_W-1:0]  pend_vec;
    logic              take_irq;
    logic [ADDR_W-1:0] sp_act;
    logic [ADDR_W-1:0] vec_ofs;
    logic [WORD_W-1:0] ofs_word;

    irq_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_active_i (irq_active_i),
        .irq_level_i  (irq_level_i),
        .irq_vec_i    (irq_vec_i),
        .mask_i       (r_q.sr[SR_MHI:SR_MLO]),
        .svc_i        (r_q.svc),
        .pend_lvl_o   (pend_lvl),
        .pend_vec_o   (pend_vec),
        .accept_o     (take_irq)
    );

    assign sp_act   = r_q.sr[SR_SUPER] ? r_q.ssp : r_q.usp;
    assign vec_ofs  = {{(ADDR_W-VEC_W-2){1'b0}}, r_q.vec, 2'b00};
    assign ofs_word = {{(WORD_W-VEC_W-2){1'b0}}, r_q.vec, 2'b00};

    always_comb begin
        r_d         = r_q;
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (r_q.state)
            ST_RSP_H: begin
                bus_req_o  = 1'b1;
                bus_addr_o = '0;
                if (bus_ack_i) begin
                    r_d.hold  = bus_rdata_i;
                    r_d.state = ST_RSP_L;
                end
            end
            ST_RSP_L: begin
                bus_req_o  = 1'b1;
                bus_addr_o = WORD_B;
                if (bus_ack_i) begin
                    r_d.ssp   = {r_q.hold, bus_rdata_i};
                    r_d.state = ST_RPC_H;
                end
            end
            ST_RPC_H: begin
                bus_req_o  = 1'b1;
                bus_addr_o = LONG_B;
                if (bus_ack_i) begin
                    r_d.hold  = bus_rdata_i;
                    r_d.state = ST_RPC_L;
                end
            end
            ST_RPC_L: begin
                bus_req_o  = 1'b1;
                bus_addr_o = LONG_B + WORD_B;
                if (bus_ack_i) begin
                    r_d.pc    = {r_q.hold, bus_rdata_i};
                    r_d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (sr_we_i)  r_d.sr  = sr_wd_i;
                if (pc_we_i)  r_d.pc  = pc_wd_i;
                if (usp_we_i) r_d.usp = usp_wd_i;
                if (insn_done_i) begin
                    if (trap_req_i) begin
                        r_d.vec   = trap_sw_i ? VEC_W'(TRAP_BASE) + VEC_W'(trap_num_i)
                                              : trap_vec_i;
                        r_d.irq   = 1'b0;
                        r_d.state = ST_PUSH_OFS;
                    end else if (take_irq) begin
                        r_d.vec   = pend_vec;
                        r_d.svc   = pend_lvl;
                        r_d.irq   = 1'b1;
                        r_d.state = ST_PUSH_OFS;
                    end else if (pend_lvl < r_q.svc) begin
                        r_d.svc = pend_lvl;
                    end
                end
            end
            ST_PUSH_OFS: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = sp_act - WORD_B;
                bus_wdata_o = ofs_word;
                if (bus_ack_i) begin
                    if (r_q.sr[SR_SUPER]) r_d.ssp = sp_act - WORD_B;
                    else                  r_d.usp = sp_act - WORD_B;
                    r_d.state = ST_PUSH_PCH;
                end
            end
            ST_PUSH_PCH: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = sp_act - LONG_B;
                bus_wdata_o = r_q.pc[ADDR_W-1:WORD_W];
                if (bus_ack_i) begin
                    if (r_q.sr[SR_SUPER]) r_d.ssp = sp_act - LONG_B;
                    else                  r_d.usp = sp_act - LONG_B;
                    r_d.state = ST_PUSH_PCL;
                end
            end
            ST_PUSH_PCL: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = sp_act + WORD_B;
                bus_wdata_o = r_q.pc[WORD_W-1:0];
                if (bus_ack_i) r_d.state = ST_PUSH_SR;
            end
            ST_PUSH_SR: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = sp_act - WORD_B;
                bus_wdata_o = r_q.sr;
                if (bus_ack_i) begin
                    if (r_q.sr[SR_SUPER]) r_d.ssp = sp_act - WORD_B;
                    else                  r_d.usp = sp_act - WORD_B;
                    r_d.sr[SR_SUPER] = 1'b1;
                    r_d.sr[SR_TRACE] = 1'b0;
                    if (r_q.irq) r_d.sr[SR_MHI:SR_MLO] = r_q.svc;
                    r_d.state = ST_VEC_H;
                end
            end
            ST_VEC_H: begin
                bus_req_o  = 1'b1;
                bus_addr_o = vbr_i + vec_ofs;
                if (bus_ack_i) begin
                    r_d.hold  = bus_rdata_i;
                    r_d.state = ST_VEC_L;
                end
            end
            ST_VEC_L: begin
                bus_req_o  = 1'b1;
                bus_addr_o = vbr_i + vec_ofs + WORD_B;
                if (bus_ack_i) begin
                    r_d.pc    = {r_q.hold, bus_rdata_i};
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_RSP_H;
            r_q.sr    <= RESET_SR;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.state != ST_IDLE);
    assign sr_o        = r_q.sr;
    assign pc_o        = r_q.pc;
    assign ssp_o       = r_q.ssp;
    assign usp_o       = r_q.usp;
    assign svc_level_o = r_q.svc;

    // R11: an open request keeps its address until acknowledged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)));

    // R5: without an acceptance the in-service level never rises
    p_svc_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && insn_done_i && !take_irq) |=> (r_q.svc <= $past(r_q.svc)));

    // R8: vector fetch runs in supervisor state with tracing off
    p_super_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_VEC_H || r_q.state == ST_VEC_L) |-> (r_q.sr[SR_SUPER] && !r_q.sr[SR_TRACE]));

    // R4: an accepted interrupt level is in the mask by the vector fetch
    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_VEC_H && r_q.irq) |-> (r_q.sr[SR_MHI:SR_MLO] == r_q.svc));

    // R10: the PC moves only on the last read of a sequence while busy
    p_pc_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && r_q.state != ST_RPC_L && r_q.state != ST_VEC_L) |=> $stable(r_q.pc));
endmodule

// File: tb/irq_entry_unit_tb.sv
module irq_entry_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VBR = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_active_i = 1'b0;
    logic [2:0]  irq_level_i = '0;
    logic [7:0]  irq_vec_i = '0;
    logic        insn_done_i = 1'b0;
    logic        trap_req_i = 1'b0;
    logic        trap_sw_i = 1'b0;
    logic [3:0]  trap_num_i = '0;
    logic [7:0]  trap_vec_i = '0;
    logic        sr_we_i = 1'b0;
    logic [15:0] sr_wd_i = '0;
    logic        pc_we_i = 1'b0;
    logic [31:0] pc_wd_i = '0;
    logic        usp_we_i = 1'b0;
    logic [31:0] usp_wd_i = '0;
    logic        bus_req_o, bus_we_o;
    logic [31:0] bus_addr_o;
    logic [15:0] bus_wdata_o;
    logic [15:0] bus_rdata_i = '0;
    logic        bus_ack_i = 1'b0;
    logic        busy_o;
    logic [15:0] sr_o;
    logic [31:0] pc_o, ssp_o, usp_o;
    logic [2:0]  svc_level_o;

    irq_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .irq_active_i(irq_active_i), .irq_level_i(irq_level_i), .irq_vec_i(irq_vec_i),
        .insn_done_i(insn_done_i), .trap_req_i(trap_req_i), .trap_sw_i(trap_sw_i),
        .trap_num_i(trap_num_i), .trap_vec_i(trap_vec_i), .vbr_i(VBR),
        .sr_we_i(sr_we_i), .sr_wd_i(sr_wd_i), .pc_we_i(pc_we_i), .pc_wd_i(pc_wd_i),
        .usp_we_i(usp_we_i), .usp_wd_i(usp_wd_i),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i),
        .busy_o(busy_o), .sr_o(sr_o), .pc_o(pc_o), .ssp_o(ssp_o), .usp_o(usp_o),
        .svc_level_o(svc_level_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] mem [0:4095];
    logic [31:0] wl_addr [0:15];
    logic [15:0] wl_data [0:15];
    int wcnt = 0;
    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // word memory model, one-cycle acknowledge
    always @(negedge clk) begin
        if (bus_req_o && !bus_ack_i) begin
            bus_ack_i = 1'b1;
            if (bus_we_o) begin
                mem[bus_addr_o[12:1]] = bus_wdata_o;
                if (wcnt < 16) begin
                    wl_addr[wcnt] = bus_addr_o;
                    wl_data[wcnt] = bus_wdata_o;
                end
                wcnt = wcnt + 1;
            end else begin
                bus_rdata_i = mem[bus_addr_o[12:1]];
            end
        end else begin
            bus_ack_i = 1'b0;
        end
    end

    function automatic logic [31:0] pcv(input logic [7:0] v);
        return {8'hC0, v, 8'h01, v};
    endfunction

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sr(input logic [15:0] v);
        @(negedge clk); sr_we_i = 1'b1; sr_wd_i = v;
        @(negedge clk); sr_we_i = 1'b0;
    endtask

    task automatic set_irq(input bit act, input logic [2:0] lvl, input logic [7:0] vec);
        @(negedge clk); irq_active_i = act; irq_level_i = lvl; irq_vec_i = vec;
        cyc(2);
    endtask

    task automatic strobe(input bit trap, input bit sw, input logic [3:0] num, input logic [7:0] tv);
        @(negedge clk);
        wcnt = 0;
        insn_done_i = 1'b1; trap_req_i = trap; trap_sw_i = sw; trap_num_i = num; trap_vec_i = tv;
        @(negedge clk);
        insn_done_i = 1'b0; trap_req_i = 1'b0; trap_sw_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input logic [31:0] sp, input logic [7:0] v,
                               input logic [31:0] opc, input logic [15:0] osr);
        chk({tag, " R6 count"}, 48'(wcnt), 48'd4);
        chk({tag, " R6 ofs"},  {wl_addr[0], wl_data[0]}, {sp - 32'd2, 6'd0, v, 2'd0});
        chk({tag, " R6 pchi"}, {wl_addr[1], wl_data[1]}, {sp - 32'd6, opc[31:16]});
        chk({tag, " R6 pclo"}, {wl_addr[2], wl_data[2]}, {sp - 32'd4, opc[15:0]});
        chk({tag, " R6 sr"},   {wl_addr[3], wl_data[3]}, {sp - 32'd8, osr});
    endtask

    task automatic no_entry(input string tag, input logic [2:0] svc);
        cyc(3);
        chk({tag, " busy"}, 48'(busy_o), 48'd0);
        chk({tag, " writes"}, 48'(wcnt), 48'd0);
        chk({tag, " svc"}, 48'(svc_level_o), 48'(svc));
    endtask

    task automatic t_reset();
        wait_idle();
        chk("R1 ssp", 48'(ssp_o), 48'h1000);
        chk("R1 pc", 48'(pc_o), 48'h0400);
        chk("R1 sr", 48'(sr_o), 48'h2700);
        chk("R1 svc", 48'(svc_level_o), 48'd0);
        chk("R1 usp", 48'(usp_o), 48'd0);
    endtask

    task automatic t_masked();
        set_sr(16'h2300);
        set_irq(1'b1, 3'd2, 8'h40);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        no_entry("R3 below mask", 3'd0);
    endtask

    task automatic t_equal_level();
        set_irq(1'b1, 3'd3, 8'h41);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        chk("R10 busy at entry", 48'(busy_o), 48'd1);
        wait_idle();
        check_frame("R3 equal", 32'h1000, 8'h41, 32'h0400, 16'h2300);
        chk("R4 svc", 48'(svc_level_o), 48'd3);
        chk("R4 sr", 48'(sr_o), 48'h2300);
        chk("R6 ssp", 48'(ssp_o), 48'h0FF8);
        chk("R8 pc", 48'(pc_o), 48'(pcv(8'h41)));
    endtask

    task automatic t_nested_trace();
        set_sr(16'hA100);
        // R2: vector change at unchanged level is not captured
        @(negedge clk); irq_vec_i = 8'h77;
        cyc(2);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        wait_idle();
        check_frame("R2 same level", 32'h0FF8, 8'h41, pcv(8'h41), 16'hA100);
        chk("R8 trace cleared", 48'(sr_o), 48'h2300);
        chk("R4 svc nested", 48'(svc_level_o), 48'd3);
    endtask

    task automatic t_lower();
        set_irq(1'b0, 3'd0, 8'h00);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        no_entry("R5 drop to none", 3'd0);
    endtask

    task automatic t_partial();
        set_irq(1'b1, 3'd5, 8'h50);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        wait_idle();
        check_frame("R3 level5", 32'h0FF0, 8'h50, pcv(8'h41), 16'h2300);
        chk("R4 sr level5", 48'(sr_o), 48'h2500);
        set_irq(1'b1, 3'd2, 8'h52);
        set_sr(16'h2000);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        no_entry("R5 partial lower", 3'd2);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        wait_idle();
        check_frame("R3 after lower", 32'h0FE8, 8'h52, pcv(8'h50), 16'h2000);
        chk("R4 sr level2", 48'(sr_o), 48'h2200);
        chk("R8 pc 52", 48'(pc_o), 48'(pcv(8'h52)));
    endtask

    task automatic t_trap_user();
        set_irq(1'b0, 3'd0, 8'h00);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        cyc(2);
        @(negedge clk); usp_we_i = 1'b1; usp_wd_i = 32'h1800;
        @(negedge clk); usp_we_i = 1'b0;
        set_sr(16'h0000);
        strobe(1'b1, 1'b1, 4'd5, 8'h00);
        wait_idle();
        check_frame("R7 user stack", 32'h1800, 8'h25, pcv(8'h52), 16'h0000);
        chk("R7 usp", 48'(usp_o), 48'h17F8);
        chk("R7 ssp kept", 48'(ssp_o), 48'h0FE0);
        chk("R9 sr trap", 48'(sr_o), 48'h2000);
        chk("R9 swtrap pc", 48'(pc_o), 48'(pcv(8'h25)));
    endtask

    task automatic t_trap_first();
        set_irq(1'b1, 3'd4, 8'h44);
        strobe(1'b1, 1'b0, 4'd0, 8'h05);
        wait_idle();
        check_frame("R9 precedence", 32'h0FE0, 8'h05, pcv(8'h25), 16'h2000);
        chk("R9 svc kept", 48'(svc_level_o), 48'd0);
        chk("R9 mask kept", 48'(sr_o), 48'h2000);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        wait_idle();
        check_frame("R3 after trap", 32'h0FD8, 8'h44, pcv(8'h05), 16'h2000);
        chk("R4 svc4", 48'(svc_level_o), 48'd4);
    endtask

    task automatic t_nmi_busy();
        set_sr(16'h2700);
        set_irq(1'b1, 3'd7, 8'h70);
        strobe(1'b0, 1'b0, 4'd0, 8'd0);
        @(negedge clk);
        insn_done_i = 1'b1; sr_we_i = 1'b1; sr_wd_i = 16'h0000;
        pc_we_i = 1'b1; pc_wd_i = 32'hDEAD_0000;
        @(negedge clk);
        insn_done_i = 1'b0; sr_we_i = 1'b0; pc_we_i = 1'b0;
        wait_idle();
        cyc(3);
        check_frame("R10 nmi", 32'h0FD0, 8'h70, pcv(8'h44), 16'h2700);
        chk("R3 nmi svc", 48'(svc_level_o), 48'd7);
        chk("R10 sr", 48'(sr_o), 48'h2700);
        chk("R10 pc", 48'(pc_o), 48'(pcv(8'h70)));
        chk("R10 ssp", 48'(ssp_o), 48'h0FC8);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        mem[1] = 16'h1000;
        mem[3] = 16'h0400;
        for (int v = 0; v < 256; v++) begin
            mem[(VBR[12:0] + 13'(v * 4)) >> 1]       = pcv(8'(v))[31:16];
            mem[((VBR[12:0] + 13'(v * 4)) >> 1) + 1] = pcv(8'(v))[15:0];
        end
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_masked();
        t_equal_level();
        t_nested_trace();
        t_lower();
        t_partial();
        t_trap_user();
        t_trap_first();
        t_nmi_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule